// File: doc/BRIEF.md
# Mixed Time/Event Task Dispatcher

This block selects the task to run on one processing node. Tasks are released in two ways. Time-triggered tasks are released from a static schedule table, which is compared against a local time counter that advances on a tick input. Event-triggered tasks are released by a per-task event line, or when an interrupt service routine for the device they wait on completes. Both kinds share one ready set. Each cycle a single winner is chosen from that set under a policy chosen on a port.

Interrupt requests go into a pending set. A pending request beats every task and is served lowest request number first. The block does not execute anything. It tracks per-task state (Created, Idle, Ready, Running) and reports the current owner of the processor as a registered index, with a flag that marks an interrupt routine. A `done` strobe from the processor ends the current occupant.

Top module: `mixed_dispatch`

## Requirements
- R1: After reset, `run_valid` and `run_isr` are 0, the local time is 0 and every task is in Created, so nothing is ever chosen.
- R2: Writing a task entry with `task_tt`=1 puts it in Idle, where it is not chosen. Writing with `task_tt`=0 puts it in Ready, so it can be chosen in the next cycle.
- R3: On a `tick` cycle whose local time equals the time of the next schedule slot (slots are in ascending time order, `slot_task` gives the task), that time-triggered task moves from Idle to Ready. It runs, if it is best, one cycle later.
- R4: The local time counts ticks from 0 to `cyc_len`-1, then returns to 0 and restarts the schedule from slot 0, so the same releases repeat every cycle.
- R5: A pulse on `evt[i]` moves event-triggered task i from Idle to Ready. An event that finds the task Ready or Running has no effect.
- R6: At most one task is Running. `done` while a task runs returns that task to Idle. With no candidate left, `run_valid` drops to 0.
- R7: `policy` picks the smallest key among Ready and Running tasks. The keys are: 0 the period (rate monotonic), 1 the relative deadline (deadline monotonic), 2 the absolute deadline (earliest deadline first), 3 the fixed priority field.
- R8: Equal keys are resolved in favour of the lowest task index.
- R9: Task scheduling is preemptive. A newly ready task, or a policy change, that produces a better key displaces the running task, which goes back to Ready.
- R10: A pulse on `irq[j]` is recorded as pending. In the following cycle the routine for j is dispatched (`run_isr`=1, `run_idx`=j), and any running task returns to Ready.
- R11: Pending requests are served lowest number first. A running routine is never displaced by another request and keeps its index until `done`.
- R12: When routine j completes, every event-triggered task in Idle with its wait enable set and its wait number equal to j becomes Ready.
- R13: The absolute deadline of a task is set to the number of ticks seen since reset, at the moment of its release or creation, plus its relative deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Selection key: 0 period, 1 relative deadline, 2 absolute deadline, 3 fixed priority |
| tick | input | 1 | Advance local time by one unit |
| evt | input | NTASK | Per-task event pulses |
| irq | input | NIRQ | Interrupt request pulses |
| done | input | 1 | Current occupant completes |
| task_we | input | 1 | Write a task entry |
| task_sel | input | TIW | Task index for the write |
| task_tt | input | 1 | 1 time-triggered, 0 event-triggered |
| task_period | input | PW | Period |
| task_rdl | input | PW | Relative deadline |
| task_prio | input | PRW | Fixed priority, smaller wins |
| task_wait_en | input | 1 | Task waits on an interrupt routine |
| task_wait_irq | input | IIW | Request number the task waits on |
| slot_we | input | 1 | Write a schedule slot |
| slot_sel | input | SIW | Slot index |
| slot_time | input | TW | Local time of the release |
| slot_task | input | TIW | Task released by the slot |
| cyc_we | input | 1 | Load cycle length and slot count; restarts local time |
| cyc_len | input | TW | Cycle length in ticks (0: wrap at full range) |
| cyc_slots | input | SCW | Number of valid slots |
| run_valid | output | 1 | Something occupies the processor |
| run_isr | output | 1 | Occupant is an interrupt routine |
| run_idx | output | RIW | Task index or request number of the occupant |

## Verification
The assertions assume that `done` is only raised while something runs, that a task entry is never rewritten while that task is running, and that schedule slot times are distinct, ascending and below the cycle length. They also assume the tick count since reset stays inside its width. The directed sequences respect each of these. The random part reconfigures only after a reset, strobes `done` only while `run_valid` is high, and uses no ticks, so the absolute deadlines equal the relative ones and can be predicted exactly.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;
  typedef enum logic [1:0] {
    ST_CREATED = 2'd0,
    ST_IDLE    = 2'd1,
    ST_READY   = 2'd2,
    ST_RUN     = 2'd3
  } tstate_e;

  typedef enum logic [1:0] {
    POL_RM  = 2'd0,
    POL_DM  = 2'd1,
    POL_EDF = 2'd2,
    POL_FIX = 2'd3
  } policy_e;
endpackage

// File: rtl/mdisp_timebase.sv
module mdisp_timebase #(
  parameter int TW    = 12,
  parameter int MW    = 20,
  parameter int NSLOT = 16,
  parameter int TIW   = 3,
  localparam int SIW  = $clog2(NSLOT),
  localparam int SCW  = $clog2(NSLOT + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           cyc_we,
  input  logic [TW-1:0]  cyc_len,
  input  logic [SCW-1:0] cyc_slots,
  input  logic           slot_we,
  input  logic [SIW-1:0] slot_sel,
  input  logic [TW-1:0]  slot_time,
  input  logic [TIW-1:0] slot_task,
  output logic [TW-1:0]  now,
  output logic [TW-1:0]  len_q,
  output logic [MW-1:0]  mono,
  output logic           rel_valid,
  output logic [TIW-1:0] rel_task
);
  // schedule memory: synchronous write, asynchronous read (LUT RAM)
  logic [TW-1:0]  tbl_time [NSLOT];
  logic [TIW-1:0] tbl_task [NSLOT];
  logic [SCW-1:0] ptr;
  logic [SCW-1:0] slots_q;
  logic [SIW-1:0] ptr_ix;
  logic           last;

  always_ff @(posedge clk) begin
    if (slot_we) begin
      tbl_time[slot_sel] <= slot_time;
      tbl_task[slot_sel] <= slot_task;
    end
  end

  assign ptr_ix    = ptr[SIW-1:0];
  assign last      = (now == len_q - TW'(1));
  assign rel_valid = tick && !cyc_we && (ptr < slots_q) && (tbl_time[ptr_ix] == now);
  assign rel_task  = tbl_task[ptr_ix];

  always_ff @(posedge clk) begin
    if (rst) begin
      now     <= '0;
      len_q   <= '0;
      slots_q <= '0;
      ptr     <= '0;
      mono    <= '0;
    end else begin
      if (tick) mono <= mono + MW'(1);
      if (cyc_we) begin
        len_q   <= cyc_len;
        slots_q <= cyc_slots;
        now     <= '0;
        ptr     <= '0;
      end else if (tick) begin
        if (last) begin
          now <= '0;
          ptr <= '0;
        end else begin
          now <= now + TW'(1);
          if (rel_valid) ptr <= ptr + SCW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdisp_irq.sv
module mdisp_irq #(
  parameter int NIRQ = 4,
  localparam int IIW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] irq,
  input  logic            grant,
  output logic [NIRQ-1:0] pend,
  output logic            pend_any,
  output logic [IIW-1:0]  pend_idx
);
  logic [NIRQ-1:0] clr;

  always_comb begin
    pend_idx = '0;
    for (int j = NIRQ - 1; j >= 0; j--) begin
      if (pend[j]) pend_idx = IIW'(j);
    end
  end

  assign pend_any = |pend;
  assign clr      = grant ? (NIRQ'(1) << pend_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | irq;
  end
endmodule

// File: rtl/mdisp_pick.sv
module mdisp_pick #(
  parameter int NTASK = 8,
  parameter int KW    = 20,
  localparam int TIW  = $clog2(NTASK)
) (
  input  logic [NTASK-1:0] cand,
  input  logic [KW-1:0]    key [NTASK],
  output logic             found,
  output logic [TIW-1:0]   win
);
  logic [KW-1:0] best;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '0;
    for (int i = 0; i < NTASK; i++) begin
      if (cand[i] && (!found || key[i] < best)) begin
        found = 1'b1;
        win   = TIW'(i);
        best  = key[i];
      end
    end
  end
endmodule

// File: rtl/mixed_dispatch.sv
module mixed_dispatch #(
  parameter int NTASK = 8,
  parameter int NIRQ  = 4,
  parameter int NSLOT = 16,
  parameter int TW    = 12,
  parameter int MW    = 20,
  parameter int PW    = 16,
  parameter int PRW   = 4,
  localparam int TIW  = $clog2(NTASK),
  localparam int IIW  = $clog2(NIRQ),
  localparam int SIW  = $clog2(NSLOT),
  localparam int SCW  = $clog2(NSLOT + 1),
  localparam int RIW  = (TIW > IIW) ? TIW : IIW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       policy,
  input  logic             tick,
  input  logic [NTASK-1:0] evt,
  input  logic [NIRQ-1:0]  irq,
  input  logic             done,
  input  logic             task_we,
  input  logic [TIW-1:0]   task_sel,
  input  logic             task_tt,
  input  logic [PW-1:0]    task_period,
  input  logic [PW-1:0]    task_rdl,
  input  logic [PRW-1:0]   task_prio,
  input  logic             task_wait_en,
  input  logic [IIW-1:0]   task_wait_irq,
  input  logic             slot_we,
  input  logic [SIW-1:0]   slot_sel,
  input  logic [TW-1:0]    slot_time,
  input  logic [TIW-1:0]   slot_task,
  input  logic             cyc_we,
  input  logic [TW-1:0]    cyc_len,
  input  logic [SCW-1:0]   cyc_slots,
  output logic             run_valid,
  output logic             run_isr,
  output logic [RIW-1:0]   run_idx
);
  import mdisp_pkg::*;

  // per-task table
  tstate_e        st     [NTASK];
  logic           is_tt  [NTASK];
  logic [PW-1:0]  period [NTASK];
  logic [PW-1:0]  rdl    [NTASK];
  logic [PRW-1:0] prio   [NTASK];
  logic           wen    [NTASK];
  logic [IIW-1:0] wirq   [NTASK];
  logic [MW-1:0]  absdl  [NTASK];

  logic [TW-1:0]   now;
  logic [TW-1:0]   cyc_len_q;
  logic [MW-1:0]   mono;
  logic            rel_valid;
  logic [TIW-1:0]  rel_task;
  logic [NIRQ-1:0] irq_pend;
  logic            pend_any;
  logic [IIW-1:0]  pend_idx;

  logic            isr_act, isr_hold, isr_end, grant_isr, do_pick;
  logic [NTASK-1:0] cand, is_run, wake;
  logic [MW-1:0]   key [NTASK];
  logic            pick_found;
  logic [TIW-1:0]  pick_win;
  policy_e         pol;

  mdisp_timebase #(.TW(TW), .MW(MW), .NSLOT(NSLOT), .TIW(TIW)) u_time (
    .clk(clk), .rst(rst), .tick(tick),
    .cyc_we(cyc_we), .cyc_len(cyc_len), .cyc_slots(cyc_slots),
    .slot_we(slot_we), .slot_sel(slot_sel), .slot_time(slot_time), .slot_task(slot_task),
    .now(now), .len_q(cyc_len_q), .mono(mono),
    .rel_valid(rel_valid), .rel_task(rel_task)
  );

  assign isr_act   = run_valid && run_isr;
  assign isr_hold  = isr_act && !done;
  assign isr_end   = isr_act && done;
  assign grant_isr = pend_any && !isr_hold;
  assign do_pick   = !grant_isr && !isr_hold;
  assign pol       = policy_e'(policy);

  mdisp_irq #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst(rst), .irq(irq), .grant(grant_isr),
    .pend(irq_pend), .pend_any(pend_any), .pend_idx(pend_idx)
  );

  for (genvar g = 0; g < NTASK; g++) begin : g_task
    assign is_run[g] = (st[g] == ST_RUN);
    assign cand[g]   = (st[g] == ST_READY) || ((st[g] == ST_RUN) && !done);
    // release condition for a task found in Idle
    assign wake[g]   = is_tt[g]
                     ? (rel_valid && rel_task == TIW'(g))
                     : (evt[g] || (isr_end && wen[g] && wirq[g] == run_idx[IIW-1:0]));
    always_comb begin
      unique case (pol)
        POL_RM:  key[g] = MW'(period[g]);
        POL_DM:  key[g] = MW'(rdl[g]);
        POL_EDF: key[g] = absdl[g];
        default: key[g] = MW'(prio[g]);
      endcase
    end
  end

  mdisp_pick #(.NTASK(NTASK), .KW(MW)) u_pick (
    .cand(cand), .key(key), .found(pick_found), .win(pick_win)
  );

  // task state machine and table
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTASK; i++) begin
        st[i]     <= ST_CREATED;
        is_tt[i]  <= 1'b0;
        period[i] <= '0;
        rdl[i]    <= '0;
        prio[i]   <= '0;
        wen[i]    <= 1'b0;
        wirq[i]   <= '0;
        absdl[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NTASK; i++) begin
        unique case (st[i])
          ST_RUN: begin
            if (grant_isr) st[i] <= ST_READY;
            else if (done) st[i] <= ST_IDLE;
            else if (do_pick && pick_found && pick_win != TIW'(i)) st[i] <= ST_READY;
          end
          ST_READY: begin
            if (do_pick && pick_found && pick_win == TIW'(i)) st[i] <= ST_RUN;
          end
          ST_IDLE: begin
            if (wake[i]) begin
              st[i]    <= ST_READY;
              absdl[i] <= mono + MW'(rdl[i]);
            end
          end
          default: ;
        endcase
        if (task_we && task_sel == TIW'(i)) begin
          st[i]     <= task_tt ? ST_IDLE : ST_READY;
          is_tt[i]  <= task_tt;
          period[i] <= task_period;
          rdl[i]    <= task_rdl;
          prio[i]   <= task_prio;
          wen[i]    <= task_wait_en;
          wirq[i]   <= task_wait_irq;
          absdl[i]  <= mono + MW'(task_rdl);
        end
      end
    end
  end

  // registered occupant
  always_ff @(posedge clk) begin
    if (rst) begin
      run_valid <= 1'b0;
      run_isr   <= 1'b0;
      run_idx   <= '0;
    end else if (grant_isr) begin
      run_valid <= 1'b1;
      run_isr   <= 1'b1;
      run_idx   <= RIW'(pend_idx);
    end else if (!isr_hold) begin
      run_valid <= pick_found;
      run_isr   <= 1'b0;
      run_idx   <= pick_found ? RIW'(pick_win) : '0;
    end
  end
endmodule

// File: rtl/mdisp_chk.sv
module mdisp_chk #(
  parameter int NTASK = 8,
  parameter int NIRQ  = 4,
  parameter int TW    = 12,
  parameter int RIW   = 3,
  localparam int IIW  = $clog2(NIRQ)
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             run_valid,
  input logic             run_isr,
  input logic [RIW-1:0]   run_idx,
  input logic [NTASK-1:0] is_run,
  input logic [NIRQ-1:0]  irq_pend,
  input logic [TW-1:0]    now,
  input logic [TW-1:0]    cyc_len_q
);
  logic [IIW-1:0] low_idx;
  always_comb begin
    low_idx = '0;
    for (int j = NIRQ - 1; j >= 0; j--) begin
      if (irq_pend[j]) low_idx = IIW'(j);
    end
  end

  // R6: never two tasks running
  a_r6_single_runner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(is_run));

  // R6: the reported task is the one in Running
  a_r6_report_matches: assert property (@(posedge clk) disable iff (rst)
    (run_valid && !run_isr) |-> (is_run == (NTASK'(1) << run_idx)));

  a_r10_no_task_under_isr: assert property (@(posedge clk) disable iff (rst)
    !(run_valid && !run_isr) |-> (is_run == '0));

  // R10 and R11: pending request dispatched next cycle, lowest first
  a_r10_isr_next_cycle: assert property (@(posedge clk) disable iff (rst)
    ((|irq_pend) && !(run_valid && run_isr)) |=>
      (run_valid && run_isr && run_idx == RIW'($past(low_idx))));

  // R11: routine holds until done
  a_r11_isr_holds: assert property (@(posedge clk) disable iff (rst)
    (run_valid && run_isr && !done) |=> (run_valid && run_isr && $stable(run_idx)));

  // R4: local time stays inside the cycle
  a_r4_time_in_cycle: assert property (@(posedge clk) disable iff (rst)
    (cyc_len_q != '0) |-> (now < cyc_len_q));
endmodule

bind mixed_dispatch mdisp_chk #(
  .NTASK(NTASK), .NIRQ(NIRQ), .TW(TW), .RIW(RIW)
) u_chk (
  .clk(clk), .rst(rst), .done(done),
  .run_valid(run_valid), .run_isr(run_isr), .run_idx(run_idx),
  .is_run(is_run), .irq_pend(irq_pend), .now(now), .cyc_len_q(cyc_len_q)
);

// File: tb/test_mixed_dispatch.sv
module test_mixed_dispatch;
  localparam int NT = 8, NI = 4, NS = 16, TW = 12, PW = 16, PRW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, tick, done, task_we, task_tt, task_wait_en, slot_we, cyc_we;
  logic [1:0] policy;
  logic [NT-1:0] evt;
  logic [NI-1:0] irq;
  logic [2:0] task_sel, slot_task, run_idx;
  logic [PW-1:0] task_period, task_rdl;
  logic [PRW-1:0] task_prio;
  logic [1:0] task_wait_irq;
  logic [3:0] slot_sel;
  logic [TW-1:0] slot_time, cyc_len;
  logic [4:0] cyc_slots;
  logic run_valid, run_isr;

  mixed_dispatch i_mixed_dispatch (
    .clk(clk), .rst(rst), .policy(policy), .tick(tick), .evt(evt), .irq(irq), .done(done),
    .task_we(task_we), .task_sel(task_sel), .task_tt(task_tt), .task_period(task_period),
    .task_rdl(task_rdl), .task_prio(task_prio), .task_wait_en(task_wait_en),
    .task_wait_irq(task_wait_irq), .slot_we(slot_we), .slot_sel(slot_sel),
    .slot_time(slot_time), .slot_task(slot_task), .cyc_we(cyc_we), .cyc_len(cyc_len),
    .cyc_slots(cyc_slots), .run_valid(run_valid), .run_isr(run_isr), .run_idx(run_idx)
  );

  int checks = 0, errors = 0;
  int b_per [NT], b_rdl [NT], b_abs [NT], b_pri [NT];
  int b_mono = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_tick(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; step(); tick = 1'b0; b_mono++;
    end
  endtask

  task automatic do_done();
    done = 1'b1; step(); done = 1'b0;
  endtask

  task automatic mk_task(int idx, bit tt, int per, int rd, int pr, bit we, int wi);
    task_we = 1'b1; task_sel = 3'(idx); task_tt = tt; task_period = PW'(per);
    task_rdl = PW'(rd); task_prio = PRW'(pr); task_wait_en = we; task_wait_irq = 2'(wi);
    b_per[idx] = per; b_rdl[idx] = rd; b_pri[idx] = pr; b_abs[idx] = b_mono + rd;
    step(); task_we = 1'b0;
  endtask

  task automatic mk_slot(int s, int t, int tk);
    slot_we = 1'b1; slot_sel = 4'(s); slot_time = TW'(t); slot_task = 3'(tk);
    step(); slot_we = 1'b0;
  endtask

  task automatic set_cycle(int len, int n);
    cyc_we = 1'b1; cyc_len = TW'(len); cyc_slots = 5'(n);
    step(); cyc_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; b_mono = 0;
  endtask

  // expected winner: smallest key, lowest index on ties (R7, R8)
  function automatic int best(int pol, bit [NT-1:0] mask);
    int bi = -1, bk = 0, k;
    for (int i = 0; i < NT; i++) begin
      k = (pol == 0) ? b_per[i] : (pol == 1) ? b_rdl[i] : (pol == 2) ? b_abs[i] : b_pri[i];
      if (mask[i] && (bi < 0 || k < bk)) begin bi = i; bk = k; end
    end
    return bi;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b0; done = 1'b0; evt = '0; irq = '0; policy = 2'd0;
    task_we = 1'b0; task_sel = '0; task_tt = 1'b0; task_period = '0; task_rdl = '0;
    task_prio = '0; task_wait_en = 1'b0; task_wait_irq = '0; slot_we = 1'b0;
    slot_sel = '0; slot_time = '0; slot_task = '0; cyc_we = 1'b0; cyc_len = '0; cyc_slots = '0;
    void'($urandom(32'd20240517));
    do_reset();

    // R1: reset state
    chk("R1 valid", int'(run_valid), 0);
    chk("R1 isr", int'(run_isr), 0);
    do_tick(3);
    chk("R1 nothing chosen", int'(run_valid), 0);

    // R2: time-triggered tasks wait in Idle
    mk_task(4, 1'b1, 100, 50, 9, 1'b0, 0);
    mk_task(5, 1'b1, 100, 50, 9, 1'b0, 0);
    step();
    chk("R2 tt idle", int'(run_valid), 0);

    // R2, R7, R8: event-triggered tasks ready at once
    mk_task(0, 1'b0, 40, 30, 3, 1'b0, 0);
    mk_task(1, 1'b0, 20, 35, 2, 1'b0, 0);
    mk_task(2, 1'b0, 50, 10, 1, 1'b0, 0);
    mk_task(3, 1'b0, 20, 10, 0, 1'b0, 0);
    step();
    chk("R7 R8 rate monotonic tie", int'(run_idx), 1);
    chk("R2 et ready", int'(run_valid), 1);
    policy = 2'd1; step();
    chk("R9 R8 deadline monotonic tie", int'(run_idx), 2);
    policy = 2'd3; step();
    chk("R7 fixed priority", int'(run_idx), 3);
    do_done(); chk("R6 next after done", int'(run_idx), 2);
    do_done(); chk("R6 next after done", int'(run_idx), 1);
    do_done(); chk("R6 next after done", int'(run_idx), 0);
    do_done(); chk("R6 empty set", int'(run_valid), 0);

    // R5: event release and ignored event
    evt = 8'h02; step(); evt = '0; step();
    chk("R5 event releases", int'(run_idx), 1);
    evt = 8'h02; step(); evt = '0;
    do_done(); chk("R5 done", int'(run_valid), 0);
    step(); chk("R5 event on running ignored", int'(run_valid), 0);

    // R3, R4: schedule table and wrap
    mk_slot(0, 2, 4);
    mk_slot(1, 7, 5);
    set_cycle(10, 2);
    do_tick(2); step();
    chk("R3 before slot time", int'(run_valid), 0);
    do_tick(1); chk("R3 released not yet running", int'(run_valid), 0);
    step(); chk("R3 slot 0 task", int'(run_idx), 4);
    do_done();
    do_tick(4); step(); chk("R3 gap", int'(run_valid), 0);
    do_tick(1); step(); chk("R3 slot 1 task", int'(run_idx), 5);
    do_done();
    do_tick(4); step(); chk("R4 across wrap", int'(run_valid), 0);
    do_tick(1); step(); chk("R4 repeat next cycle", int'(run_idx), 4);
    chk("R4 not isr", int'(run_isr), 0);
    do_done();

    // R13, R9: earliest deadline first
    set_cycle(0, 0);
    policy = 2'd2;
    mk_task(0, 1'b0, 40, 30, 3, 1'b0, 0);
    step(); chk("R13 edf first", int'(run_idx), 0);
    do_tick(15);
    mk_task(6, 1'b0, 60, 20, 5, 1'b0, 0);
    step(); chk("R13 later absolute deadline loses", int'(run_idx), best(2, 8'h41));
    policy = 2'd1; step();
    chk("R9 preempt on policy change", int'(run_idx), 6);
    do_done(); chk("R9 preempted resumes", int'(run_idx), 0);
    do_done(); chk("R6 idle", int'(run_valid), 0);

    // R10, R11, R12: interrupt routines
    mk_task(7, 1'b0, 10, 5, 7, 1'b1, 2);
    step(); chk("R12 waiter first run", int'(run_idx), 7);
    do_done();
    evt = 8'h02; step(); evt = '0; step();
    chk("R10 task before irq", int'(run_idx), 1);
    irq = 4'b0110; step(); irq = '0;
    chk("R10 one cycle to pending", int'(run_isr), 0);
    step();
    chk("R10 isr runs", int'(run_isr), 1);
    chk("R11 lowest first", int'(run_idx), 1);
    step(); chk("R11 holds", int'(run_idx), 1);
    do_done();
    chk("R11 second routine", int'(run_isr), 1);
    chk("R11 second index", int'(run_idx), 2);
    do_done();
    chk("R12 preempted task back", int'(run_idx), 1);
    chk("R12 not isr", int'(run_isr), 0);
    step(); chk("R12 waiter woken", int'(run_idx), 7);
    do_done(); do_done();
    chk("R6 drained", int'(run_valid), 0);

    // random part: R7, R8 across all policies
    for (int it = 0; it < 20; it++) begin
      int pol, exp;
      bit [NT-1:0] mask;
      do_reset();
      pol = int'($urandom_range(0, 3));
      policy = 2'(pol);
      for (int t = 0; t < NT; t++)
        mk_task(t, 1'b0, int'($urandom_range(1, 8)), int'($urandom_range(1, 8)),
                int'($urandom_range(0, 7)), 1'b0, 0);
      step();
      mask = '1;
      for (int t = 0; t < NT; t++) begin
        exp = best(pol, mask);
        chk("R7 R8 random order", int'(run_idx), exp);
        mask[exp] = 1'b0;
        do_done();
      end
      chk("R6 random drained", int'(run_valid), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule